// File: doc/BRIEF.md
# Pulse-by-Pulse Overcurrent Gate Controller

This synchronous controller sits between a PWM command and the gate stage of one power switch. In normal operation it follows the PWM command through a push-pull gate driver. It also watches an overcurrent comparator input, which arrives already synchronized to the clock.

After each PWM rising edge the controller ignores the comparator for a programmable number of clock cycles. This blanking window covers the turn-on delay of the sensing path. Once the window has passed, a comparator assertion trips a latch. The latch puts the normal driver in high impedance, enables a separate high-resistance discharge path, and raises a fault level toward the upstream controller. The switch stays off for the rest of the PWM period, and only the next PWM rising edge clears the latch.

All outputs come from registered state, so each one changes in the cycle after the clock edge that samples the causing input.

Top module: `ocp_gate_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the following cycle shows `gate_drv`=0, `drv_en`=1, `soft_en`=0 and `fault_out`=0.
- R2: After any edge that samples `pwm_in` low, `gate_drv`=0 and `drv_en`=1 in the next cycle, whatever the latch holds.
- R3: An edge that samples `pwm_in` high, when the previous sample was low, with no trip, gives `gate_drv`=1, `drv_en`=1 and `soft_en`=0 in the next cycle.
- R4: For the BLANK_CYC edges that follow a PWM rising edge, `oc_in` has no effect, and the outputs stay in the on state.
- R5: When `oc_in` is sampled high while the gate is on and blanking has ended, the next cycle shows `gate_drv`=0, `drv_en`=0 (high impedance), `soft_en`=1 and `fault_out`=1.
- R6: Once tripped, the off state with the soft path enabled holds while `pwm_in` stays high, even if `oc_in` returns low.
- R7: `fault_out` stays set from the trip until the next PWM rising edge clears it, including while `pwm_in` is low.
- R8: If a PWM rising edge and an `oc_in` assertion are sampled at the same edge, the latch is cleared, the gate turns on and blanking starts.
- R9: When `pwm_in` is sampled low after a trip, `soft_en` drops and the driver is re-enabled driving low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwm_in | input | 1 | PWM command from the controller |
| oc_in | input | 1 | Synchronized overcurrent comparator output |
| gate_drv | output | 1 | Level driven by the normal gate driver |
| drv_en | output | 1 | Normal driver enable; 0 puts the driver in high impedance |
| soft_en | output | 1 | Enable for the slow high-resistance discharge path |
| fault_out | output | 1 | Trip level reported to the controller |

## Verification
The bench places comparator pulses on the last blanked edge and on the first armed edge. A timer that is off by one in either direction therefore either trips early or misses a trip. It applies a PWM rising edge and an overcurrent in the same cycle; a design that gave the comparator priority would latch a trip at turn-on. It also drops the comparator while the PWM is still high and holds the fault across the low phase. A latch that followed the comparator would release the gate, and a fault flag tied to the PWM level would clear too early. A PWM pulse cut off during blanking, and a reset asserted in mid-trip, check that the gate returns to driven low.

// File: rtl/ocp_pkg.sv
package ocp_pkg;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_ON   = 2'd1,
        ST_SOFT = 2'd2
    } gate_st_e;

    typedef struct packed {
        logic level;
        logic drv_on;
        logic soft_on;
    } gate_cmd_t;

    function automatic gate_cmd_t decode_gate(input gate_st_e st);
        gate_cmd_t c;
        case (st)
            ST_ON:   c = '{level: 1'b1, drv_on: 1'b1, soft_on: 1'b0};
            ST_SOFT: c = '{level: 1'b0, drv_on: 1'b0, soft_on: 1'b1};
            default: c = '{level: 1'b0, drv_on: 1'b1, soft_on: 1'b0};
        endcase
        return c;
    endfunction

endpackage

// File: rtl/ocp_pwm_edge.sv
module ocp_pwm_edge (
    input  logic clk,
    input  logic rst,
    input  logic pwm_in,
    output logic rise
);
    logic pwm_q;

    always_ff @(posedge clk) begin
        if (rst) pwm_q <= 1'b0;
        else     pwm_q <= pwm_in;
    end

    assign rise = pwm_in & ~pwm_q;
endmodule

// File: rtl/ocp_blank_timer.sv
module ocp_blank_timer #(
    parameter int BLANK_CYC = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic pwm_in,
    input  logic rise,
    output logic armed
);
    localparam int CW = (BLANK_CYC < 1) ? 1 : $clog2(BLANK_CYC + 1);
    localparam logic [CW-1:0] LOAD = CW'(BLANK_CYC);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !pwm_in) cnt <= '0;
        else if (rise)      cnt <= LOAD;
        else if (cnt != '0) cnt <= cnt - 1'b1;
    end

    assign armed = (cnt == '0);
endmodule

// File: rtl/ocp_trip_fsm.sv
module ocp_trip_fsm
    import ocp_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     pwm_in,
    input  logic     rise,
    input  logic     armed,
    input  logic     oc_in,
    output gate_st_e state,
    output logic     fault
);
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_OFF;
            fault <= 1'b0;
        end else if (!pwm_in) begin
            state <= ST_OFF;
        end else if (rise) begin
            state <= ST_ON;
            fault <= 1'b0;
        end else if (state == ST_ON && armed && oc_in) begin
            state <= ST_SOFT;
            fault <= 1'b1;
        end
    end
endmodule

// File: rtl/ocp_gate_ctrl.sv
module ocp_gate_ctrl
    import ocp_pkg::*;
#(
    parameter int BLANK_CYC = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic pwm_in,
    input  logic oc_in,
    output logic gate_drv,
    output logic drv_en,
    output logic soft_en,
    output logic fault_out
);
    logic      rise;
    logic      armed;
    gate_st_e  state;
    gate_cmd_t cmd;

    ocp_pwm_edge u_edge (
        .clk    (clk),
        .rst    (rst),
        .pwm_in (pwm_in),
        .rise   (rise)
    );

    ocp_blank_timer #(.BLANK_CYC(BLANK_CYC)) u_blank (
        .clk    (clk),
        .rst    (rst),
        .pwm_in (pwm_in),
        .rise   (rise),
        .armed  (armed)
    );

    ocp_trip_fsm u_fsm (
        .clk    (clk),
        .rst    (rst),
        .pwm_in (pwm_in),
        .rise   (rise),
        .armed  (armed),
        .oc_in  (oc_in),
        .state  (state),
        .fault  (fault_out)
    );

    assign cmd      = decode_gate(state);
    assign gate_drv = cmd.level;
    assign drv_en   = cmd.drv_on;
    assign soft_en  = cmd.soft_on;
endmodule

// File: rtl/ocp_gate_ctrl_chk.sv
module ocp_gate_ctrl_chk #(
    parameter int BLANK_CYC = 5
) (
    input logic clk,
    input logic rst,
    input logic pwm_in,
    input logic oc_in,
    input logic gate_drv,
    input logic drv_en,
    input logic soft_en,
    input logic fault_out
);
    localparam int SAT = BLANK_CYC + 2;
    localparam int SW  = $clog2(SAT + 1);

    logic          prev_pwm;
    logic [SW-1:0] since_rise;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_pwm   <= 1'b0;
            since_rise <= SW'(SAT);
        end else begin
            prev_pwm <= pwm_in;
            if (pwm_in && !prev_pwm)       since_rise <= '0;
            else if (since_rise != SW'(SAT)) since_rise <= since_rise + 1'b1;
        end
    end

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!gate_drv && drv_en && !soft_en && !fault_out));

    // R2
    pwm_low_off_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(pwm_in) |-> (!gate_drv && drv_en));

    // R3
    rise_on_chk: assert property (@(posedge clk) disable iff (rst)
        (pwm_in && !prev_pwm) |=> (gate_drv && drv_en && !soft_en && !fault_out));

    // R4
    blank_window_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(soft_en) |-> (since_rise >= SW'(BLANK_CYC + 1)));

    // R5
    trip_outputs_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(soft_en) |-> (!drv_en && !gate_drv && fault_out));

    // R6
    trip_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (soft_en && pwm_in) |=> soft_en);

    // R7
    fault_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (fault_out && !(pwm_in && !prev_pwm)) |=> fault_out);

    // R9
    soft_release_chk: assert property (@(posedge clk) disable iff (rst)
        (soft_en && !pwm_in) |=> (!soft_en && drv_en && !gate_drv));
endmodule

bind ocp_gate_ctrl ocp_gate_ctrl_chk #(.BLANK_CYC(BLANK_CYC)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .pwm_in    (pwm_in),
    .oc_in     (oc_in),
    .gate_drv  (gate_drv),
    .drv_en    (drv_en),
    .soft_en   (soft_en),
    .fault_out (fault_out)
);

// File: tb/tb_ocp_gate_ctrl.sv
module tb_ocp_gate_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int BLK = 3;
    localparam int NV = 26;

    // vector: {pwm, oc, gate, en, soft, fault} ; outputs expected after the edge
    localparam logic [5:0] VEC [NV] = '{
        6'b00_0100, // 0  R2 idle off
        6'b10_1100, // 1  R3 rise
        6'b11_1100, // 2  R4 blanked
        6'b11_1100, // 3  R4 blanked
        6'b11_1100, // 4  R4 last blanked edge
        6'b11_0011, // 5  R5 trip
        6'b10_0011, // 6  R6 hold with oc low
        6'b00_0101, // 7  R9 release, R7 fault held
        6'b01_0101, // 8  R7 fault held in low phase
        6'b11_1100, // 9  R8 rise with oc
        6'b10_1100, // 10 R4
        6'b10_1100, // 11 R4
        6'b10_1100, // 12 R4
        6'b10_1100, // 13 R3 armed, no oc
        6'b00_0100, // 14 R2 normal off
        6'b10_1100, // 15 R3 rise
        6'b01_0100, // 16 R2 pulse cut in blanking
        6'b10_1100, // 17 R3 rise
        6'b10_1100, // 18
        6'b10_1100, // 19
        6'b10_1100, // 20
        6'b11_0011, // 21 R5 trip on first armed edge
        6'b11_0011, // 22 R6
        6'b10_0011, // 23 R6
        6'b00_0101, // 24 R9
        6'b10_1100  // 25 R7 fault cleared by rise
    };
    localparam int VREQ [NV] = '{2,3,4,4,4,5,6,9,7,8,4,4,4,3,2,3,2,3,3,3,3,5,6,6,9,7};

    logic clk = 1'b0;
    logic rst, pwm_in, oc_in;
    logic gate_drv, drv_en, soft_en, fault_out;
    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ocp_gate_ctrl #(.BLANK_CYC(BLK)) dut (
        .clk(clk), .rst(rst), .pwm_in(pwm_in), .oc_in(oc_in),
        .gate_drv(gate_drv), .drv_en(drv_en), .soft_en(soft_en), .fault_out(fault_out)
    );

    task automatic check(input int req, input logic [3:0] exp);
        logic [3:0] act;
        act = {gate_drv, drv_en, soft_en, fault_out};
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL R%0d: outputs {gate,en,soft,fault} = %b, expected %b", req, act, exp);
        end
    endtask

    task automatic step(input logic p, input logic o);
        @(negedge clk);
        pwm_in = p;
        oc_in  = o;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 2000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run hung, actual timeout, expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        rst = 1'b1; pwm_in = 1'b0; oc_in = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check(1, 4'b0100); // R1 reset state
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][5], VEC[i][4]);
            check(VREQ[i], VEC[i][3:0]);
        end

        // R1: reset during a trip with pwm high
        step(1'b1, 1'b0);
        repeat (BLK) step(1'b1, 1'b0);
        step(1'b1, 1'b1);
        check(5, 4'b0011); // R5
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        check(1, 4'b0100); // R1 trip cleared by reset
        @(negedge clk);
        rst = 1'b0;
        // pwm already high when reset drops: first sample counts as a rise (R3)
        @(posedge clk);
        #1;
        check(3, 4'b1100);
        // R4 with comparator held high from the rise
        step(1'b1, 1'b1);
        check(4, 4'b1100);
        step(1'b0, 1'b0);
        check(2, 4'b0100);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule